// File: doc/BRIEF.md
# Single-Bank Command Legality Monitor

This block tracks one bank of a double-data-rate synchronous DRAM and judges every command aimed at it. On each rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable lines into a command. It keeps a bank state machine with a single down-counter for the activate, precharge and burst windows. When a command is not permitted in the state the bank reaches at that edge, it raises a one-cycle violation pulse.

A memory-controller bench or an on-chip monitor places one instance per bank. The surrounding logic supplies a bank-match signal, which is also high for a precharge-all. The monitor reports its current state on a 3-bit output so that the controller's own bookkeeping can be compared against it. Checks between banks, data timing and refresh scheduling belong to other blocks.

Top module: `bank_cmd_checker`

## Requirements
- R1: While synchronous reset `rst` is high at a clock edge, the bank enters idle (state code 0), the counter clears and `violation` is low on the next cycle.
- R2: ACTIVE (`{csN,rasN,casN,weN}` = 0011) to an idle bank moves it to row opening (code 1) on the next cycle. Absent further commands, it reports row open (code 2) from the edge T_RCD cycles after the ACTIVE edge, and a command at that edge is judged as if the row were open.
- R3: PRECHARGE (0010) from row open, reading or writing moves the bank to closing (code 5). It reports idle (code 0) from the edge T_RP cycles after the PRECHARGE edge.
- R4: In row opening, closing, read-with-autoclose (code 6) and write-with-autoclose (code 7), any command other than NOP (0111) or DESELECT (`csN` high) is a violation.
- R5: In idle, ACTIVE, REFRESH (0001) and LOAD MODE (0000) are accepted, and REFRESH and LOAD MODE leave the bank idle. READ, WRITE and PRECHARGE are violations.
- R6: In row open, reading (code 3) and writing (code 4), READ (0101), WRITE (0100) and PRECHARGE are accepted, and ACTIVE, REFRESH and LOAD MODE are violations. A READ or WRITE with `autoPre` low enters code 3 or code 4 and restarts the burst window.
- R7: Reading or writing returns to row open at the edge BURST_CLKS cycles after the last accepted READ or WRITE edge.
- R8: READ or WRITE with `autoPre` high enters code 6 or code 7 respectively. The bank returns to idle at the edge BURST_CLKS+T_RP cycles after that command.
- R9: A command is judged only when `cke` was high at the previous edge and is high at the current one. Otherwise it is ignored, with no violation and no state change from it, while the counter keeps running.
- R10: With `csN` high, or with `bankHit` low, the command is treated as NOP. The pattern 0110 is reserved and is a violation in every state.
- R11: `violation` is high for exactly the cycle after an illegal command edge. The state then evolves as if a NOP had been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| autoPre | input | 1 | Auto-precharge address bit for READ/WRITE |
| bankHit | input | 1 | Command addresses this bank (or all banks) |
| violation | output | 1 | One-cycle pulse after an illegal command |
| bankState | output | 3 | Current bank state code |

## Verification
Several rules hold on every cycle and are checked continuously by properties. A bank that is opening never falls straight back to idle. The closing and autoclose states leave only for idle or a fresh activation. A low `cke` or an unaddressed command never yields a violation. The exact window lengths need scenario tests, and so does the legality split between states, including judging a command against the state reached at its own edge. Burst restart, and the counter running on while commands are ignored, are also shown only by the directed scenarios, which compare the reported state and pulse against hand-derived cycle counts.

// File: rtl/bank_chk_pkg.sv
package bank_chk_pkg;

  typedef enum logic [2:0] {
    BS_IDLE     = 3'd0,
    BS_OPENING  = 3'd1,
    BS_OPEN     = 3'd2,
    BS_READ     = 3'd3,
    BS_WRITE    = 3'd4,
    BS_CLOSING  = 3'd5,
    BS_READ_AC  = 3'd6,
    BS_WRITE_AC = 3'd7
  } bankState_e;

  // Lower three bits follow {rasN,casN,weN}; C_DES is chip not selected.
  typedef enum logic [3:0] {
    C_LMR = 4'b0000,
    C_REF = 4'b0001,
    C_PRE = 4'b0010,
    C_ACT = 4'b0011,
    C_WR  = 4'b0100,
    C_RD  = 4'b0101,
    C_RSV = 4'b0110,
    C_NOP = 4'b0111,
    C_DES = 4'b1000
  } cmd_e;

  typedef struct packed {
    logic loadOpen;
    logic loadClose;
    logic loadBurst;
    logic loadBurstClose;
  } timerCtl_t;

endpackage

// File: rtl/bank_cmd_decode.sv
module bank_cmd_decode
  import bank_chk_pkg::*;
(
  input  logic csN,
  input  logic rasN,
  input  logic casN,
  input  logic weN,
  input  logic bankHit,
  output cmd_e cmd
);

  always_comb begin
    if (csN)
      cmd = C_DES;
    else if (!bankHit)
      cmd = C_NOP;
    else
      cmd = cmd_e'({1'b0, rasN, casN, weN});
  end

endmodule

// File: rtl/bank_timer_path.sv
module bank_timer_path
  import bank_chk_pkg::*;
#(
  parameter int T_RCD      = 3,
  parameter int T_RP       = 3,
  parameter int BURST_CLKS = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cke,
  input  timerCtl_t ctl,
  output logic      cntZero,
  output logic      checkEn
);

  localparam int LONGEST_A = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int LONGEST   = (LONGEST_A > BURST_CLKS + T_RP) ? LONGEST_A : BURST_CLKS + T_RP;
  localparam int CNT_W     = $clog2(LONGEST + 1);

  localparam logic [CNT_W-1:0] OPEN_LD   = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] CLOSE_LD  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] BURST_LD  = CNT_W'(BURST_CLKS - 1);
  localparam logic [CNT_W-1:0] BCLOSE_LD = CNT_W'(BURST_CLKS + T_RP - 1);

  logic [CNT_W-1:0] cntQ;
  logic             ckePrevQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ     <= '0;
      ckePrevQ <= 1'b0;
    end else begin
      ckePrevQ <= cke;
      if (ctl.loadOpen)
        cntQ <= OPEN_LD;
      else if (ctl.loadClose)
        cntQ <= CLOSE_LD;
      else if (ctl.loadBurst)
        cntQ <= BURST_LD;
      else if (ctl.loadBurstClose)
        cntQ <= BCLOSE_LD;
      else if (cntQ != '0)
        cntQ <= cntQ - 1'b1;
    end
  end

  assign cntZero = (cntQ == '0);
  assign checkEn = ckePrevQ & cke;

endmodule

// File: rtl/bank_fsm_ctrl.sv
module bank_fsm_ctrl
  import bank_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cmd_e       cmd,
  input  logic       autoPre,
  input  logic       checkEn,
  input  logic       cntZero,
  output timerCtl_t  ctl,
  output bankState_e stateQ,
  output logic       violation
);

  bankState_e effState;
  bankState_e nextState;
  logic       isQuiet;
  logic       allowed;
  logic       accept;
  logic       illegal;
  logic       vioQ;

  // State the bank reaches at this edge once an expiring window is applied.
  always_comb begin
    effState = stateQ;
    if (cntZero) begin
      case (stateQ)
        BS_OPENING, BS_READ, BS_WRITE:       effState = BS_OPEN;
        BS_CLOSING, BS_READ_AC, BS_WRITE_AC: effState = BS_IDLE;
        default:                             effState = stateQ;
      endcase
    end
  end

  always_comb begin
    isQuiet = (cmd == C_NOP) || (cmd == C_DES);
    case (effState)
      BS_IDLE:
        allowed = isQuiet || (cmd == C_ACT) || (cmd == C_REF) || (cmd == C_LMR);
      BS_OPEN, BS_READ, BS_WRITE:
        allowed = isQuiet || (cmd == C_RD) || (cmd == C_WR) || (cmd == C_PRE);
      default:
        allowed = isQuiet;
    endcase
    accept  = checkEn && allowed && !isQuiet;
    illegal = checkEn && !allowed;
  end

  always_comb begin
    nextState = effState;
    ctl       = '0;
    if (accept) begin
      case (cmd)
        C_ACT: begin
          nextState    = BS_OPENING;
          ctl.loadOpen = 1'b1;
        end
        C_RD: begin
          if (autoPre) begin
            nextState          = BS_READ_AC;
            ctl.loadBurstClose = 1'b1;
          end else begin
            nextState     = BS_READ;
            ctl.loadBurst = 1'b1;
          end
        end
        C_WR: begin
          if (autoPre) begin
            nextState          = BS_WRITE_AC;
            ctl.loadBurstClose = 1'b1;
          end else begin
            nextState     = BS_WRITE;
            ctl.loadBurst = 1'b1;
          end
        end
        C_PRE: begin
          nextState     = BS_CLOSING;
          ctl.loadClose = 1'b1;
        end
        default: nextState = BS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= BS_IDLE;
      vioQ   <= 1'b0;
    end else begin
      stateQ <= nextState;
      vioQ   <= illegal;
    end
  end

  assign violation = vioQ;

endmodule

// File: rtl/bank_cmd_checker.sv
module bank_cmd_checker
  import bank_chk_pkg::*;
#(
  parameter int T_RCD      = 3,
  parameter int T_RP       = 3,
  parameter int BURST_CLKS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       csN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  input  logic       cke,
  input  logic       autoPre,
  input  logic       bankHit,
  output logic       violation,
  output logic [2:0] bankState
);

  cmd_e       cmd;
  timerCtl_t  ctl;
  logic       cntZero;
  logic       checkEn;
  bankState_e stateQ;

  bank_cmd_decode u_decode (
    .csN     (csN),
    .rasN    (rasN),
    .casN    (casN),
    .weN     (weN),
    .bankHit (bankHit),
    .cmd     (cmd)
  );

  bank_timer_path #(
    .T_RCD      (T_RCD),
    .T_RP       (T_RP),
    .BURST_CLKS (BURST_CLKS)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .cke     (cke),
    .ctl     (ctl),
    .cntZero (cntZero),
    .checkEn (checkEn)
  );

  bank_fsm_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .autoPre   (autoPre),
    .checkEn   (checkEn),
    .cntZero   (cntZero),
    .ctl       (ctl),
    .stateQ    (stateQ),
    .violation (violation)
  );

  assign bankState = stateQ;

endmodule

// File: rtl/bank_cmd_checker_sva.sv
module bank_cmd_checker_sva (
  input logic       clk,
  input logic       rst,
  input logic       csN,
  input logic       bankHit,
  input logic       cke,
  input logic       violation,
  input logic [2:0] bankState
);

  // R2: an opening bank can only move towards an open row
  p_open_not_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (bankState == 3'd1) |=> (bankState != 3'd0));

  // R3: closing leaves only for idle or, from idle, a new activation
  p_close_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (bankState == 3'd5) |=> (bankState inside {3'd5, 3'd0, 3'd1}));

  // R8: read with autoclose ends in idle
  p_read_ac_exit_r8: assert property (@(posedge clk) disable iff (rst)
    (bankState == 3'd6) |=> (bankState inside {3'd6, 3'd0, 3'd1}));

  // R8: write with autoclose ends in idle
  p_write_ac_exit_r8: assert property (@(posedge clk) disable iff (rst)
    (bankState == 3'd7) |=> (bankState inside {3'd7, 3'd0, 3'd1}));

  // R9: a low clock enable suppresses checking
  p_cke_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !cke |=> !violation);

  // R10: deselect or another bank is never flagged
  p_quiet_cmd_r10: assert property (@(posedge clk) disable iff (rst)
    (csN || !bankHit) |=> !violation);

endmodule

bind bank_cmd_checker bank_cmd_checker_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .csN       (csN),
  .bankHit   (bankHit),
  .cke       (cke),
  .violation (violation),
  .bankState (bankState)
);

// File: tb/bank_cmd_checker_bench.sv
module bank_cmd_checker_bench;

  localparam int T_RCD      = 3;
  localparam int T_RP       = 3;
  localparam int BURST_CLKS = 4;

  localparam logic [3:0] K_LMR = 4'b0000;
  localparam logic [3:0] K_REF = 4'b0001;
  localparam logic [3:0] K_PRE = 4'b0010;
  localparam logic [3:0] K_ACT = 4'b0011;
  localparam logic [3:0] K_WR  = 4'b0100;
  localparam logic [3:0] K_RD  = 4'b0101;
  localparam logic [3:0] K_RSV = 4'b0110;
  localparam logic [3:0] K_NOP = 4'b0111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic cke = 1'b1, autoPre = 1'b0, bankHit = 1'b1;
  logic violation;
  logic [2:0] bankState;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bank_cmd_checker #(
    .T_RCD(T_RCD), .T_RP(T_RP), .BURST_CLKS(BURST_CLKS)
  ) u_bank_cmd_checker (
    .clk(clk), .rst(rst), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .autoPre(autoPre), .bankHit(bankHit),
    .violation(violation), .bankState(bankState)
  );

  task automatic issue(input logic [3:0] c, input logic ap = 1'b0,
                       input logic hit = 1'b1, input logic ck = 1'b1);
    {csN, rasN, casN, weN} = c;
    autoPre = ap;
    bankHit = hit;
    cke     = ck;
    @(negedge clk);
    {csN, rasN, casN, weN} = K_NOP;
    autoPre = 1'b0;
    bankHit = 1'b1;
    cke     = 1'b1;
  endtask

  task automatic expect_out(input logic [2:0] st, input logic vio, input string tag);
    nChecks++;
    if (bankState !== st || violation !== vio) begin
      nFails++;
      $display("FAIL %s: state=%0d expected %0d, violation=%0d expected %0d",
               tag, bankState, st, violation, vio);
    end
  endtask

  task automatic nops_expect(input int n, input logic [2:0] st, input string tag);
    for (int i = 0; i < n; i++) begin
      issue(K_NOP);
      expect_out(st, 1'b0, tag);
    end
  endtask

  task automatic open_row();
    issue(K_ACT);
    nops_expect(T_RCD - 1, 3'd1, "R2 opening");
    issue(K_NOP);
    expect_out(3'd2, 1'b0, "R2 open");
  endtask

  task automatic close_row();
    issue(K_PRE);
    expect_out(3'd5, 1'b0, "R3 enter closing");
    nops_expect(T_RP - 1, 3'd5, "R3 closing");
    issue(K_NOP);
    expect_out(3'd0, 1'b0, "R3 idle");
  endtask

  task automatic t_reset();
    rst = 1'b1;
    issue(K_NOP);
    issue(K_ACT);
    expect_out(3'd0, 1'b0, "R1 reset state");
    rst = 1'b0;
    issue(K_NOP);
    issue(K_NOP);
    expect_out(3'd0, 1'b0, "R1 after reset");
  endtask

  task automatic t_activate();
    issue(K_ACT);
    expect_out(3'd1, 1'b0, "R2 enter opening");
    nops_expect(T_RCD - 1, 3'd1, "R2 opening window");
    issue(K_NOP);
    expect_out(3'd2, 1'b0, "R2 open after T_RCD");
    close_row();
  endtask

  task automatic t_idle_rules();
    issue(K_REF);  expect_out(3'd0, 1'b0, "R5 refresh in idle");
    issue(K_LMR);  expect_out(3'd0, 1'b0, "R5 load mode in idle");
    issue(K_RD);   expect_out(3'd0, 1'b1, "R5 read in idle");
    issue(K_NOP);  expect_out(3'd0, 1'b0, "R11 pulse one cycle");
    issue(K_WR);   expect_out(3'd0, 1'b1, "R5 write in idle");
    issue(K_PRE);  expect_out(3'd0, 1'b1, "R5 precharge in idle");
    issue(K_RSV);  expect_out(3'd0, 1'b1, "R10 reserved in idle");
    issue(4'b1011); expect_out(3'd0, 1'b0, "R10 deselect ignores strobes");
    issue(K_ACT, 1'b0, 1'b0); expect_out(3'd0, 1'b0, "R10 other bank");
    issue(K_RD, 1'b0, 1'b0);  expect_out(3'd0, 1'b0, "R10 other bank read");
  endtask

  task automatic t_transient();
    issue(K_ACT);
    issue(K_RD);  expect_out(3'd1, 1'b1, "R4 read while opening");
    issue(K_NOP); expect_out(3'd1, 1'b0, "R11 window keeps running");
    issue(K_NOP); expect_out(3'd2, 1'b0, "R11 open on time");
    issue(K_PRE);
    issue(K_ACT); expect_out(3'd5, 1'b1, "R4 activate while closing");
    issue(K_NOP); expect_out(3'd5, 1'b0, "R4 still closing");
    issue(K_NOP); expect_out(3'd0, 1'b0, "R4 idle on time");
  endtask

  task automatic t_bursts();
    open_row();
    issue(K_RD);  expect_out(3'd3, 1'b0, "R6 read from open");
    nops_expect(2, 3'd3, "R7 reading");
    issue(K_RD);  expect_out(3'd3, 1'b0, "R6 read restarts burst");
    nops_expect(BURST_CLKS - 1, 3'd3, "R7 restarted burst");
    issue(K_NOP); expect_out(3'd2, 1'b0, "R7 back to open");
    issue(K_WR);  expect_out(3'd4, 1'b0, "R6 write from open");
    issue(K_ACT); expect_out(3'd4, 1'b1, "R6 activate while writing");
    nops_expect(BURST_CLKS - 2, 3'd4, "R7 writing");
    issue(K_NOP); expect_out(3'd2, 1'b0, "R7 write done");
    issue(K_REF); expect_out(3'd2, 1'b1, "R6 refresh in open");
    issue(K_LMR); expect_out(3'd2, 1'b1, "R6 load mode in open");
    issue(K_RD);
    issue(K_WR);  expect_out(3'd4, 1'b0, "R6 write during read");
    close_row();
  endtask

  task automatic t_autoclose();
    open_row();
    issue(K_RD, 1'b1); expect_out(3'd6, 1'b0, "R8 read autoclose");
    issue(K_RD);       expect_out(3'd6, 1'b1, "R4 read during autoclose");
    nops_expect(BURST_CLKS + T_RP - 2, 3'd6, "R8 read autoclose window");
    issue(K_NOP);      expect_out(3'd0, 1'b0, "R8 read autoclose idle");
    open_row();
    issue(K_WR, 1'b1); expect_out(3'd7, 1'b0, "R8 write autoclose");
    nops_expect(BURST_CLKS + T_RP - 1, 3'd7, "R8 write autoclose window");
    issue(K_NOP);      expect_out(3'd0, 1'b0, "R8 write autoclose idle");
  endtask

  task automatic t_cke();
    issue(K_ACT, 1'b0, 1'b1, 1'b0); expect_out(3'd0, 1'b0, "R9 cke low ignored");
    issue(K_RD);                    expect_out(3'd0, 1'b0, "R9 cke just risen ignored");
    issue(K_RD);                    expect_out(3'd0, 1'b1, "R9 checking resumes");
    issue(K_ACT);                   expect_out(3'd1, 1'b0, "R9 activate");
    issue(K_NOP, 1'b0, 1'b1, 1'b0); expect_out(3'd1, 1'b0, "R9 cke low opening");
    issue(K_NOP, 1'b0, 1'b1, 1'b0); expect_out(3'd1, 1'b0, "R9 cke low opening");
    issue(K_NOP);                   expect_out(3'd2, 1'b0, "R9 window ran during cke low");
    close_row();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_activate();
    t_idle_rules();
    t_transient();
    t_bursts();
    t_autoclose();
    t_cke();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule